// File: doc/BRIEF.md
# Rotating Gate Distributor

The block takes one gate or trigger stream and deals successive pulses out across a bank of up to eight output lanes. Each new rising edge of the incoming gate picks the next higher lane, and the chosen lane then mirrors the incoming gate for as long as it stays high, one clock later. Only one lane is ever high at a time.

How many lanes take part is the sum of two control values, a manual setting and a modulation setting, capped at the lane count. A total of zero mutes the block: gates pass through to no lane and the rotation position is frozen. A second pair of controls is added in the same way to pick the dealing algorithm. Today every code deals upward, and the decoder leaves room for later algorithms.

When the lane count is lowered below the current position, the next gate restarts the rotation at lane 0. A lane that has already been picked keeps the gate until the gate ends, even if the controls move in the meantime.

Top module: `rot_gate_dist`

## Requirements
- R1: After reset every lane is low, and the first gate with a nonzero lane count goes to lane 0 (bit 0 of `out`).
- R2: The lane count is count_knob + count_cv taken as unsigned numbers and limited to 8. For example 2+1 gives 3, and 6+5 gives 8.
- R3: With a lane count C greater than 0, successive gates go to lanes 0, 1, ..., C-1, then back to lane 0. Lane k is bit k of `out`.
- R4: A gate whose rising edge sees a lane count of 0 drives no lane. It also leaves the position unchanged, so the next gate with a nonzero count takes the lane it would have taken anyway.
- R5: If the stored position is at or above the lane count when a gate rises, that gate goes to lane 0 and the following gate goes to lane 1, or to lane 0 when the count is 1.
- R6: At most one bit of `out` is high in any cycle.
- R7: The picked lane is high in every cycle that follows a cycle with gate_in high, starting from the rising edge. Every lane is low in the cycle after gate_in is sampled low.
- R8: The mode total is mode_knob + mode_cv, limited to 7. Every mode code, including codes with no algorithm of their own, deals lanes in upward rotation.
- R9: Lowering or raising the lane count while a gate is high does not change the lane that gate holds. The new count takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_in | input | 1 | Incoming gate or trigger, synchronous to clk |
| count_knob | input | 4 | Manual part of the lane count |
| count_cv | input | 4 | Modulation part of the lane count |
| mode_knob | input | 3 | Manual part of the algorithm code |
| mode_cv | input | 3 | Modulation part of the algorithm code |
| out | output | 8 | Lane outputs, bit k is lane k |

## Verification
The assertions take gate_in to be already synchronous to clk. They also take every gate to be separated from the next by at least one sampled low cycle, so that each pulse produces exactly one detected rising edge. The bench changes all inputs on the falling clock edge and keeps at least one low cycle between gates. The control inputs may change at any time, including in the middle of a gate, because the block reads the lane count only at a rising edge. The bench moves them mid-gate on purpose.

// File: rtl/rgd_pkg.sv
package rgd_pkg;
  localparam int LANES_DEF  = 8;
  localparam int KNOB_W_DEF = 4;
  localparam int MODE_W_DEF = 3;

  typedef enum logic {ALG_ROT_UP = 1'b0, ALG_FALLBACK = 1'b1} alg_t;

  // Sum of two unsigned controls, limited to lim.
  function automatic int sat_sum(input int a, input int b, input int lim);
    return (a + b > lim) ? lim : a + b;
  endfunction

  // Lane to use at a rising edge: restart at 0 when the stored position is out of range.
  function automatic int pick_lane(input int pos, input int cnt);
    return (pos >= cnt) ? 0 : pos;
  endfunction

  // Next position after lane in upward rotation over cnt lanes.
  function automatic int step_up(input int lane, input int cnt);
    return (lane + 1 >= cnt) ? 0 : lane + 1;
  endfunction

  // Codes without an algorithm of their own map to the fallback, which deals upward.
  function automatic alg_t decode_mode(input int code);
    return (code == 0) ? ALG_ROT_UP : ALG_FALLBACK;
  endfunction
endpackage

// File: rtl/rgd_edge.sv
module rgd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_rise
);
  logic gate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_d <= 1'b0;
    else        gate_d <= gate_in;
  end

  assign gate_rise = gate_in & ~gate_d;
endmodule

// File: rtl/rgd_ctrl.sv
module rgd_ctrl
  import rgd_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int KNOB_W = KNOB_W_DEF,
  parameter int MODE_W = MODE_W_DEF,
  localparam int CW      = $clog2(LANES + 1),
  localparam int MODE_MX = (1 << MODE_W) - 1
) (
  input  logic [KNOB_W-1:0] count_knob,
  input  logic [KNOB_W-1:0] count_cv,
  input  logic [MODE_W-1:0] mode_knob,
  input  logic [MODE_W-1:0] mode_cv,
  output logic [CW-1:0]     cnt,
  output alg_t              alg
);
  int mode_total;

  always_comb begin
    cnt        = CW'(sat_sum(int'(count_knob), int'(count_cv), LANES));
    mode_total = sat_sum(int'(mode_knob), int'(mode_cv), MODE_MX);
    alg        = decode_mode(mode_total);
  end
endmodule

// File: rtl/rgd_rotator.sv
module rgd_rotator
  import rgd_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  localparam int CW = $clog2(LANES + 1),
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_in,
  input  logic          gate_rise,
  input  logic [CW-1:0] cnt,
  input  alg_t          alg,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] sel,
  output logic          active
);
  logic [PW-1:0] pick;
  logic [PW-1:0] nxt;

  always_comb begin
    pick = PW'(pick_lane(int'(ptr), int'(cnt)));
    case (alg)
      ALG_ROT_UP:   nxt = PW'(step_up(int'(pick), int'(cnt)));
      default:      nxt = PW'(step_up(int'(pick), int'(cnt)));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      sel    <= '0;
      active <= 1'b0;
    end else if (gate_rise && cnt != '0) begin
      sel    <= pick;
      ptr    <= nxt;
      active <= 1'b1;
    end else if (!gate_in) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/rgd_lane_dec.sv
module rgd_lane_dec #(
  parameter int LANES = 8,
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [PW-1:0]    sel,
  input  logic             active,
  output logic [LANES-1:0] lanes
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes[k] = active && (sel == PW'(k));
  end
endmodule

// File: rtl/rot_gate_dist.sv
module rot_gate_dist
  import rgd_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int KNOB_W = KNOB_W_DEF,
  parameter int MODE_W = MODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_in,
  input  logic [KNOB_W-1:0] count_knob,
  input  logic [KNOB_W-1:0] count_cv,
  input  logic [MODE_W-1:0] mode_knob,
  input  logic [MODE_W-1:0] mode_cv,
  output logic [LANES-1:0]  out
);
  localparam int CW = $clog2(LANES + 1);
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;

  logic          gate_rise;
  logic [CW-1:0] cnt;
  alg_t          alg;
  logic [PW-1:0] ptr;
  logic [PW-1:0] sel;
  logic          active;

  rgd_edge edge_i (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .gate_rise(gate_rise)
  );

  rgd_ctrl #(.LANES(LANES), .KNOB_W(KNOB_W), .MODE_W(MODE_W)) ctrl_i (
    .count_knob(count_knob), .count_cv(count_cv),
    .mode_knob(mode_knob), .mode_cv(mode_cv),
    .cnt(cnt), .alg(alg)
  );

  rgd_rotator #(.LANES(LANES)) rot_i (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .gate_rise(gate_rise),
    .cnt(cnt), .alg(alg), .ptr(ptr), .sel(sel), .active(active)
  );

  rgd_lane_dec #(.LANES(LANES)) dec_i (
    .sel(sel), .active(active), .lanes(out)
  );
endmodule

// File: rtl/rgd_checker.sv
module rgd_checker #(
  parameter int LANES = 8,
  parameter int CW = 4,
  parameter int PW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_in,
  input logic             gate_rise,
  input logic [CW-1:0]    cnt,
  input logic [PW-1:0]    ptr,
  input logic [LANES-1:0] out
);
  assert_cnt_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= LANES);

  assert_rise_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rise && cnt != '0) |=> (out != '0));

  assert_zero_mute_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rise && cnt == '0) |=> (out == '0 && $stable(ptr)));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rise && cnt != '0 && int'(ptr) >= int'(cnt)) |=> out[0]);

  assert_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out));

  assert_gate_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_in |=> (out == '0));

  assert_lane_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_in && out != '0) |=> (out == '0 || $stable(out)));
endmodule

bind rot_gate_dist rgd_checker #(.LANES(LANES), .CW(CW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .gate_rise(gate_rise),
  .cnt(cnt), .ptr(ptr), .out(out)
);

// File: tb/rot_gate_dist_tb_top.sv
module rot_gate_dist_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate_in = 1'b0;
  logic [3:0] count_knob = '0;
  logic [3:0] count_cv = '0;
  logic [2:0] mode_knob = '0;
  logic [2:0] mode_cv = '0;
  logic [7:0] out;

  int checks = 0;
  int errors = 0;
  int pos = 0;

  rot_gate_dist dut_i (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in),
    .count_knob(count_knob), .count_cv(count_cv),
    .mode_knob(mode_knob), .mode_cv(mode_cv), .out(out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (out !== exp) begin
      errors++;
      $display("FAIL %s: out=%b expected=%b at %0t", req, out, exp, $time);
    end
    checks++;
    if ($countones(out) > 1) begin
      errors++;
      $display("FAIL R6: out=%b expected at most one bit high", out);
    end
  endtask

  // Lane count as the requirements give it, in the bench's own terms.
  function automatic int lanes_now();
    int s;
    s = count_knob + count_cv;
    if (s > 8) s = 8;
    return s;
  endfunction

  // Expected lane pattern for a gate whose rising edge is seen now; updates the model position.
  function automatic logic [7:0] expect_gate();
    int c;
    int lane;
    c = lanes_now();
    if (c == 0) return 8'h00;
    lane = (pos < c) ? pos : 0;
    pos = (lane == c - 1) ? 0 : lane + 1;
    return 8'h01 << lane;
  endfunction

  // One gate of len high cycles; inputs change on falling edges.
  task automatic pulse(input string req, input int len);
    logic [7:0] exp;
    @(negedge clk);
    exp = expect_gate();
    gate_in = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check(req, exp);
    end
    gate_in = 1'b0;
    @(negedge clk);
    check("R7", 8'h00);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    rst_n = 1'b1;
    pos = 0;
    count_knob = 4'd5;
    count_cv = 4'd0;
    pulse("R1", 2);
  endtask

  task automatic t_rotate();
    for (int g = 0; g < 7; g++) pulse("R3", 1 + g % 3);
  endtask

  task automatic t_sum_sat();
    count_knob = 4'd2; count_cv = 4'd1;
    for (int g = 0; g < 4; g++) pulse("R2", 1);
    count_knob = 4'd6; count_cv = 4'd5;
    for (int g = 0; g < 9; g++) pulse("R2", 2);
    count_knob = 4'd15; count_cv = 4'd15;
    pulse("R2", 1);
  endtask

  task automatic t_zero();
    count_knob = 4'd0; count_cv = 4'd0;
    pulse("R4", 3);
    pulse("R4", 1);
    count_knob = 4'd8;
    pulse("R4", 1);
    pulse("R4", 1);
  endtask

  task automatic t_shrink();
    count_knob = 4'd8; count_cv = 4'd0;
    while (pos != 6) pulse("R3", 1);
    count_knob = 4'd2; count_cv = 4'd1;
    pulse("R5", 2);
    pulse("R5", 1);
    count_knob = 4'd0; count_cv = 4'd1;
    pulse("R5", 1);
  endtask

  task automatic t_modes();
    count_knob = 4'd3; count_cv = 4'd1;
    mode_knob = 3'd0; mode_cv = 3'd3;
    for (int g = 0; g < 5; g++) pulse("R8", 1);
    mode_knob = 3'd7; mode_cv = 3'd7;
    for (int g = 0; g < 5; g++) pulse("R8", 2);
    mode_knob = 3'd1; mode_cv = 3'd0;
    pulse("R8", 1);
  endtask

  task automatic t_hold();
    logic [7:0] exp;
    count_knob = 4'd6; count_cv = 4'd0;
    @(negedge clk);
    exp = expect_gate();
    gate_in = 1'b1;
    @(negedge clk);
    check("R9", exp);
    count_knob = 4'd1;
    @(negedge clk);
    check("R9", exp);
    count_knob = 4'd0;
    @(negedge clk);
    check("R9", exp);
    count_knob = 4'd8;
    @(negedge clk);
    check("R9", exp);
    gate_in = 1'b0;
    @(negedge clk);
    check("R7", 8'h00);
    count_knob = 4'd2;
    pulse("R9", 1);
    pulse("R9", 1);
  endtask

  initial begin
    t_reset();
    t_rotate();
    t_sum_sat();
    t_zero();
    t_shrink();
    t_modes();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected end before timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule